// File: doc/BRIEF.md
# Compare-and-Branch Fusion Detector

This block sits between the instruction decoders and the micro-op queue. Each cycle it receives up to two decoded instruction records, one per slot. Each record holds an operation class, a condition code, two source register fields and a target field. When slot 0 holds a compare and slot 1 in the same cycle holds a conditional jump whose condition is on the fusable list, the two are merged into a single compare-and-branch micro-op. Any other pair passes through as two separate micro-ops, in their original order. A count output says how many micro-ops are valid.

The list of fusable conditions covers the equality and unsigned conditions. It also covers the four signed magnitude conditions: less, greater-or-equal, less-or-equal and greater. An alias mnemonic such as "not greater-or-equal" has the same condition code as its partner, so it fuses in the same way. Fusion works in both 32-bit and 64-bit mode. The result is held in a single output register, with a valid/ready handshake towards the queue.

Top module: `cmp_branch_fuser`

## Requirements
- R1: When `in_ready` is high and both slots are valid, with slot 0 of class CMP (1) and slot 1 of class JCC (2) carrying a fusable condition, the result is a single micro-op. It has `out_count` = 1 and `out0_cls` = FUSED (5), and all slot-1 output fields are zero. The other class codes are ALU = 0, MEM = 3 and JMP = 4.
- R2: The fused micro-op takes its condition code and target from the jump, and both of its source fields from the compare.
- R3: The signed conditions fuse: less = 12, greater-or-equal = 13, less-or-equal = 14, greater = 15. Each alias mnemonic uses the same code as its partner (not-greater-or-equal = 12, not-less = 13, not-greater = 14, not-less-or-equal = 15).
- R4: The conditions below = 2, above-or-equal = 3, equal = 4, not-equal = 5, below-or-equal = 6 and above = 7 fuse. Overflow = 0, no-overflow = 1, sign = 8, no-sign = 9, parity = 10 and no-parity = 11 do not fuse.
- R5: The `mode_64` input (0 = 32-bit, 1 = 64-bit) does not change the fusion decision.
- R6: When both slots are valid and the pair does not qualify, `out_count` = 2. Slot 0's record then appears unchanged on `out0_*` and slot 1's record unchanged on `out1_*`.
- R7: When exactly one slot is valid, `out_count` = 1, its record appears unchanged on `out0_*`, and `out1_*` is zero. Fusion never pairs records that were presented in different cycles.
- R8: A record accepted at a clock edge appears on the outputs right after that edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, all outputs hold steady.
- R9: After reset `out_valid` = 0 and `out_count` = 0, and `out_count` is zero exactly when `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_64 | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| in0_valid | input | 1 | Slot 0 holds a record |
| in0_cls | input | 3 | Slot 0 operation class |
| in0_cond | input | 4 | Slot 0 condition code |
| in0_src_a | input | REG_W | Slot 0 first source register |
| in0_src_b | input | REG_W | Slot 0 second source register |
| in0_target | input | TGT_W | Slot 0 target field |
| in1_valid | input | 1 | Slot 1 holds a record |
| in1_cls | input | 3 | Slot 1 operation class |
| in1_cond | input | 4 | Slot 1 condition code |
| in1_src_a | input | REG_W | Slot 1 first source register |
| in1_src_b | input | REG_W | Slot 1 second source register |
| in1_target | input | TGT_W | Slot 1 target field |
| in_ready | output | 1 | The block accepts inputs at the next edge |
| out_ready | input | 1 | The queue takes the output |
| out_valid | output | 1 | The output holds micro-ops |
| out_count | output | 2 | Number of valid output micro-ops |
| out0_cls | output | 3 | Output micro-op 0 class |
| out0_cond | output | 4 | Output micro-op 0 condition |
| out0_src_a | output | REG_W | Output micro-op 0 first source |
| out0_src_b | output | REG_W | Output micro-op 0 second source |
| out0_target | output | TGT_W | Output micro-op 0 target |
| out1_cls | output | 3 | Output micro-op 1 class |
| out1_cond | output | 4 | Output micro-op 1 condition |
| out1_src_a | output | REG_W | Output micro-op 1 first source |
| out1_src_b | output | REG_W | Output micro-op 1 second source |
| out1_target | output | TGT_W | Output micro-op 1 target |

## Verification
The hardest situation to create is a compare and a jump that arrive in different cycles, or in swapped slots. The block must then leave them unfused. Directed tests send a compare alone in slot 1 and a jump in slot 0 on the following cycle, and also a jump-then-compare pair. The other hard case is backpressure: a fused result must stay frozen while a new pair waits at the inputs. To create it, the bench holds `out_ready` low across an accepted pair, changes the inputs, and checks that the output and `in_ready` do not move.

// File: rtl/cbf_pkg.sv
// Package: shared class and condition encodings for the fusion detector.
// Assumes 3-bit class and 4-bit condition fields in every decoded record.
package cbf_pkg;
    localparam int CLS_W  = 3;
    localparam int COND_W = 4;

    localparam logic [CLS_W-1:0] CLS_ALU   = 3'd0;
    localparam logic [CLS_W-1:0] CLS_CMP   = 3'd1;
    localparam logic [CLS_W-1:0] CLS_JCC   = 3'd2;
    localparam logic [CLS_W-1:0] CLS_MEM   = 3'd3;
    localparam logic [CLS_W-1:0] CLS_JMP   = 3'd4;
    localparam logic [CLS_W-1:0] CLS_FUSED = 3'd5;

    localparam logic [COND_W-1:0] CC_OVF  = 4'd0;
    localparam logic [COND_W-1:0] CC_NOVF = 4'd1;
    localparam logic [COND_W-1:0] CC_BLW  = 4'd2;
    localparam logic [COND_W-1:0] CC_AEQ  = 4'd3;
    localparam logic [COND_W-1:0] CC_EQ   = 4'd4;
    localparam logic [COND_W-1:0] CC_NE   = 4'd5;
    localparam logic [COND_W-1:0] CC_BEQ  = 4'd6;
    localparam logic [COND_W-1:0] CC_ABV  = 4'd7;
    localparam logic [COND_W-1:0] CC_LT   = 4'd12;
    localparam logic [COND_W-1:0] CC_GE   = 4'd13;
    localparam logic [COND_W-1:0] CC_LE   = 4'd14;
    localparam logic [COND_W-1:0] CC_GT   = 4'd15;
endpackage

// File: rtl/cbf_cond_qual.sv
// Module: decides whether a jump condition code may join a compare.
// Assumes aliased mnemonics already share one code, so one code per test.
module cbf_cond_qual
    import cbf_pkg::*;
#(
    parameter bit ALLOW_SIGNED = 1'b1
) (
    input  logic [COND_W-1:0] cond,
    output logic              fusable
);
    logic basic_ok;
    logic signed_ok;

    // Equality and unsigned conditions that always qualify.
    always_comb begin
        case (cond)
            CC_BLW, CC_AEQ, CC_EQ, CC_NE, CC_BEQ, CC_ABV: basic_ok = 1'b1;
            default:                                      basic_ok = 1'b0;
        endcase
    end

    generate
        if (ALLOW_SIGNED) begin : g_signed
            // Signed magnitude conditions qualify in this variant.
            always_comb begin
                case (cond)
                    CC_LT, CC_GE, CC_LE, CC_GT: signed_ok = 1'b1;
                    default:                    signed_ok = 1'b0;
                endcase
            end
        end else begin : g_nosigned
            assign signed_ok = 1'b0;
        end
    endgenerate

    assign fusable = basic_ok | signed_ok;
endmodule

// File: rtl/cbf_pair_merge.sv
// Module: combinational merge of two decoded slots into one or two micro-ops.
// Assumes slot 0 is older than slot 1; outputs stay in that order.
module cbf_pair_merge
    import cbf_pkg::*;
#(
    parameter int REG_W        = 5,
    parameter int TGT_W        = 16,
    parameter bit ALLOW_SIGNED = 1'b1,
    parameter bit FUSE_IN_64   = 1'b1,
    localparam int REC_W       = CLS_W + COND_W + 2*REG_W + TGT_W
) (
    input  logic             mode_64,
    input  logic             v0,
    input  logic [REC_W-1:0] rec0,
    input  logic             v1,
    input  logic [REC_W-1:0] rec1,
    output logic             any_valid,
    output logic [1:0]       n_count,
    output logic [REC_W-1:0] o0,
    output logic [REC_W-1:0] o1
);
    localparam int CLS_LO  = REC_W - CLS_W;
    localparam int COND_LO = CLS_LO - COND_W;
    localparam int TGT_HI  = TGT_W - 1;

    logic [CLS_W-1:0]  cls0, cls1;
    logic [COND_W-1:0] cond1;
    logic              cond_ok;
    logic              mode_ok;
    logic              fuse;

    assign cls0  = rec0[REC_W-1:CLS_LO];
    assign cls1  = rec1[REC_W-1:CLS_LO];
    assign cond1 = rec1[CLS_LO-1:COND_LO];

    cbf_cond_qual #(.ALLOW_SIGNED(ALLOW_SIGNED)) u_qual (
        .cond    (cond1),
        .fusable (cond_ok)
    );

    // Fusion is allowed in 32-bit mode always, in 64-bit mode per parameter.
    assign mode_ok = mode_64 ? FUSE_IN_64 : 1'b1;
    assign fuse    = v0 && v1 && (cls0 == CLS_CMP) && (cls1 == CLS_JCC)
                     && cond_ok && mode_ok;
    assign any_valid = v0 | v1;

    // Select fused, pass-through or compacted single micro-op.
    always_comb begin
        o0      = '0;
        o1      = '0;
        n_count = 2'd0;
        if (fuse) begin
            o0      = {CLS_FUSED, cond1, rec0[COND_LO-1:TGT_W], rec1[TGT_HI:0]};
            n_count = 2'd1;
        end else if (v0 && v1) begin
            o0      = rec0;
            o1      = rec1;
            n_count = 2'd2;
        end else if (v0) begin
            o0      = rec0;
            n_count = 2'd1;
        end else if (v1) begin
            o0      = rec1;
            n_count = 2'd1;
        end
    end
endmodule

// File: rtl/cbf_out_reg.sv
// Module: one-entry output register with valid/ready towards the queue.
// Assumes the downstream consumer samples when out_valid and out_ready are high.
module cbf_out_reg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          any_valid,
    input  logic [1:0]    n_count,
    input  logic [DW-1:0] n_data,
    input  logic          out_ready,
    output logic          in_ready,
    output logic          out_valid,
    output logic [1:0]    out_count,
    output logic [DW-1:0] out_data
);
    // The stage can take new data when empty or being drained.
    assign in_ready = !out_valid || out_ready;

    // Load the merged result whenever the stage can take it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_count <= 2'd0;
            out_data  <= '0;
        end else if (in_ready) begin
            out_valid <= any_valid;
            out_count <= any_valid ? n_count : 2'd0;
            out_data  <= any_valid ? n_data : '0;
        end
    end
endmodule

// File: rtl/cmp_branch_fuser.sv
// Module: top of the compare-and-branch fusion detector.
// Assumes both slots are presented together and accepted only when in_ready.
module cmp_branch_fuser
    import cbf_pkg::*;
#(
    parameter int REG_W        = 5,
    parameter int TGT_W        = 16,
    parameter bit ALLOW_SIGNED = 1'b1,
    parameter bit FUSE_IN_64   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_64,
    input  logic              in0_valid,
    input  logic [CLS_W-1:0]  in0_cls,
    input  logic [COND_W-1:0] in0_cond,
    input  logic [REG_W-1:0]  in0_src_a,
    input  logic [REG_W-1:0]  in0_src_b,
    input  logic [TGT_W-1:0]  in0_target,
    input  logic              in1_valid,
    input  logic [CLS_W-1:0]  in1_cls,
    input  logic [COND_W-1:0] in1_cond,
    input  logic [REG_W-1:0]  in1_src_a,
    input  logic [REG_W-1:0]  in1_src_b,
    input  logic [TGT_W-1:0]  in1_target,
    output logic              in_ready,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [1:0]        out_count,
    output logic [CLS_W-1:0]  out0_cls,
    output logic [COND_W-1:0] out0_cond,
    output logic [REG_W-1:0]  out0_src_a,
    output logic [REG_W-1:0]  out0_src_b,
    output logic [TGT_W-1:0]  out0_target,
    output logic [CLS_W-1:0]  out1_cls,
    output logic [COND_W-1:0] out1_cond,
    output logic [REG_W-1:0]  out1_src_a,
    output logic [REG_W-1:0]  out1_src_b,
    output logic [TGT_W-1:0]  out1_target
);
    localparam int REC_W = CLS_W + COND_W + 2*REG_W + TGT_W;

    logic [REC_W-1:0]   rec0, rec1, m0, m1;
    logic [2*REC_W-1:0] q_data;
    logic               any_valid;
    logic [1:0]         n_count;

    assign rec0 = {in0_cls, in0_cond, in0_src_a, in0_src_b, in0_target};
    assign rec1 = {in1_cls, in1_cond, in1_src_a, in1_src_b, in1_target};

    cbf_pair_merge #(
        .REG_W(REG_W), .TGT_W(TGT_W),
        .ALLOW_SIGNED(ALLOW_SIGNED), .FUSE_IN_64(FUSE_IN_64)
    ) u_merge (
        .mode_64   (mode_64),
        .v0        (in0_valid),
        .rec0      (rec0),
        .v1        (in1_valid),
        .rec1      (rec1),
        .any_valid (any_valid),
        .n_count   (n_count),
        .o0        (m0),
        .o1        (m1)
    );

    cbf_out_reg #(.DW(2*REC_W)) u_oreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_valid (any_valid),
        .n_count   (n_count),
        .n_data    ({m0, m1}),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_count (out_count),
        .out_data  (q_data)
    );

    assign {out0_cls, out0_cond, out0_src_a, out0_src_b, out0_target,
            out1_cls, out1_cond, out1_src_a, out1_src_b, out1_target} = q_data;
endmodule

// File: rtl/cbf_checker.sv
// Module: property checker for the fusion detector, attached by bind.
// Assumes the default variant (signed conditions fuse in both modes).
module cbf_checker #(
    parameter int REG_W = 5,
    parameter int TGT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in0_valid,
    input logic [2:0]       in0_cls,
    input logic [REG_W-1:0] in0_src_a,
    input logic [REG_W-1:0] in0_src_b,
    input logic             in1_valid,
    input logic [2:0]       in1_cls,
    input logic [3:0]       in1_cond,
    input logic [TGT_W-1:0] in1_target,
    input logic             in_ready,
    input logic             out_ready,
    input logic             out_valid,
    input logic [1:0]       out_count,
    input logic [2:0]       out0_cls,
    input logic [3:0]       out0_cond,
    input logic [REG_W-1:0] out0_src_a,
    input logic [REG_W-1:0] out0_src_b,
    input logic [TGT_W-1:0] out0_target
);
    function automatic logic good_cc(input logic [3:0] c);
        return (c >= 4'd2 && c <= 4'd7) || (c >= 4'd12);
    endfunction

    logic pair_fuses;
    assign pair_fuses = in_ready && in0_valid && in1_valid && in0_cls == 3'd1
                        && in1_cls == 3'd2 && good_cc(in1_cond);

    // R1
    fused_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_fuses |=> (out_valid && out_count == 2'd1 && out0_cls == 3'd5));

    // R2
    fused_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_fuses |=> (out0_cond == $past(in1_cond) && out0_src_a == $past(in0_src_a)
                        && out0_src_b == $past(in0_src_b)
                        && out0_target == $past(in1_target)));

    // R6
    pass_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && in0_valid && in1_valid && !pair_fuses) |=> (out_count == 2'd2));

    // R7
    single_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && (in0_valid ^ in1_valid)) |=> (out_count == 2'd1));

    // R8
    hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_count)
                                       && $stable(out0_cls) && $stable(out0_target)));

    // R9
    count_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_count == 2'd0) == !out_valid);
endmodule

bind cmp_branch_fuser cbf_checker #(.REG_W(REG_W), .TGT_W(TGT_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .in0_valid(in0_valid), .in0_cls(in0_cls), .in0_src_a(in0_src_a),
    .in0_src_b(in0_src_b), .in1_valid(in1_valid), .in1_cls(in1_cls),
    .in1_cond(in1_cond), .in1_target(in1_target), .in_ready(in_ready),
    .out_ready(out_ready), .out_valid(out_valid), .out_count(out_count),
    .out0_cls(out0_cls), .out0_cond(out0_cond), .out0_src_a(out0_src_a),
    .out0_src_b(out0_src_b), .out0_target(out0_target)
);

// File: tb/cmp_branch_fuser_tb.sv
module cmp_branch_fuser_tb;
    localparam int RW = 5;
    localparam int TW = 16;
    localparam int RECW = 3 + 4 + 2*RW + TW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_64 = 1'b0;
    logic in0_valid = 1'b0, in1_valid = 1'b0;
    logic [2:0] in0_cls = '0, in1_cls = '0;
    logic [3:0] in0_cond = '0, in1_cond = '0;
    logic [RW-1:0] in0_src_a = '0, in0_src_b = '0, in1_src_a = '0, in1_src_b = '0;
    logic [TW-1:0] in0_target = '0, in1_target = '0;
    logic out_ready = 1'b1;
    logic in_ready, out_valid;
    logic [1:0] out_count;
    logic [2:0] out0_cls, out1_cls;
    logic [3:0] out0_cond, out1_cond;
    logic [RW-1:0] out0_src_a, out0_src_b, out1_src_a, out1_src_b;
    logic [TW-1:0] out0_target, out1_target;

    int n_checks = 0;
    int n_fails = 0;

    always #10 clk = ~clk;

    cmp_branch_fuser #(.REG_W(RW), .TGT_W(TW)) u_dut (.*);

    typedef struct packed {
        logic [2:0] c0; logic [3:0] k0; logic [2:0] c1; logic [3:0] k1;
        logic m64; logic fuse; logic [3:0] req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{3'd1, 4'd0, 3'd2, 4'd12, 1'b0, 1'b1, 4'd3},  // R3 less, 32-bit
        '{3'd1, 4'd0, 3'd2, 4'd12, 1'b1, 1'b1, 4'd5},  // R5 less, 64-bit
        '{3'd1, 4'd0, 3'd2, 4'd13, 1'b1, 1'b1, 4'd3},  // R3 greater-or-equal
        '{3'd1, 4'd0, 3'd2, 4'd14, 1'b0, 1'b1, 4'd3},  // R3 less-or-equal
        '{3'd1, 4'd0, 3'd2, 4'd15, 1'b1, 1'b1, 4'd3},  // R3 greater
        '{3'd1, 4'd0, 3'd2, 4'd4,  1'b0, 1'b1, 4'd4},  // R4 equal
        '{3'd1, 4'd0, 3'd2, 4'd5,  1'b1, 1'b1, 4'd4},  // R4 not-equal
        '{3'd1, 4'd0, 3'd2, 4'd2,  1'b0, 1'b1, 4'd4},  // R4 below
        '{3'd1, 4'd0, 3'd2, 4'd3,  1'b1, 1'b1, 4'd4},  // R4 above-or-equal
        '{3'd1, 4'd0, 3'd2, 4'd6,  1'b0, 1'b1, 4'd4},  // R4 below-or-equal
        '{3'd1, 4'd0, 3'd2, 4'd7,  1'b1, 1'b1, 4'd4},  // R4 above
        '{3'd1, 4'd0, 3'd2, 4'd0,  1'b0, 1'b0, 4'd4},  // R4 overflow: no fuse
        '{3'd1, 4'd0, 3'd2, 4'd8,  1'b1, 1'b0, 4'd4},  // R4 sign: no fuse
        '{3'd1, 4'd0, 3'd2, 4'd11, 1'b0, 1'b0, 4'd4},  // R4 no-parity: no fuse
        '{3'd0, 4'd0, 3'd2, 4'd12, 1'b0, 1'b0, 4'd6},  // R6 ALU then jump
        '{3'd1, 4'd0, 3'd0, 4'd12, 1'b1, 1'b0, 4'd6},  // R6 compare then ALU
        '{3'd2, 4'd12, 3'd1, 4'd0, 1'b0, 1'b0, 4'd6},  // R6 jump then compare
        '{3'd1, 4'd0, 3'd4, 4'd4,  1'b0, 1'b0, 4'd6},  // R6 compare then plain jump
        '{3'd3, 4'd9, 3'd3, 4'd1,  1'b1, 1'b0, 4'd6},  // R6 two memory ops
        '{3'd1, 4'd7, 3'd2, 4'd15, 1'b0, 1'b1, 4'd2}   // R2 fields carried
    };

    task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    function automatic logic [RECW-1:0] rec(input logic [2:0] c, input logic [3:0] k,
                                             input logic [RW-1:0] a, input logic [RW-1:0] b,
                                             input logic [TW-1:0] t);
        return {c, k, a, b, t};
    endfunction

    task automatic drive(input logic v0, input logic [2:0] c0, input logic [3:0] k0,
                         input logic v1, input logic [2:0] c1, input logic [3:0] k1,
                         input int seed);
        in0_valid = v0; in0_cls = c0; in0_cond = k0;
        in0_src_a = RW'(seed + 1); in0_src_b = RW'(seed + 9);
        in0_target = TW'(seed * 331 + 17);
        in1_valid = v1; in1_cls = c1; in1_cond = k1;
        in1_src_a = RW'(seed + 4); in1_src_b = RW'(seed + 22);
        in1_target = TW'(seed * 97 + 5000);
    endtask

    task automatic idle();
        in0_valid = 1'b0; in1_valid = 1'b0;
    endtask

    function automatic logic [RECW-1:0] o0v();
        return {out0_cls, out0_cond, out0_src_a, out0_src_b, out0_target};
    endfunction
    function automatic logic [RECW-1:0] o1v();
        return {out1_cls, out1_cond, out1_src_a, out1_src_b, out1_target};
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin : main
        logic [RECW-1:0] e0, e1, held0;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 reset valid", 128'(out_valid), 128'(0));
        chk("R9 reset count", 128'(out_count), 128'(0));
        chk("R8 ready when empty", 128'(in_ready), 128'(1));
        rst_n = 1'b1;

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            mode_64 = VEC[i].m64;
            drive(1'b1, VEC[i].c0, VEC[i].k0, 1'b1, VEC[i].c1, VEC[i].k1, i * 3 + 1);
            if (VEC[i].fuse) begin
                e0 = rec(3'd5, in1_cond, in0_src_a, in0_src_b, in1_target);
                e1 = '0;
            end else begin
                e0 = rec(in0_cls, in0_cond, in0_src_a, in0_src_b, in0_target);
                e1 = rec(in1_cls, in1_cond, in1_src_a, in1_src_b, in1_target);
            end
            @(negedge clk);
            chk($sformatf("R%0d vec %0d count", VEC[i].req, i), 128'(out_count),
                128'(VEC[i].fuse ? 2'd1 : 2'd2));
            chk($sformatf("R%0d vec %0d slot0", VEC[i].req, i), 128'(o0v()), 128'(e0));
            chk($sformatf("R%0d vec %0d slot1", VEC[i].req, i), 128'(o1v()), 128'(e1));
            idle();
        end

        // R9 idle cycle drops valid
        @(negedge clk);
        chk("R9 idle valid", 128'(out_valid), 128'(0));
        chk("R9 idle count", 128'(out_count), 128'(0));

        // R7 only slot 1 valid: compacted to slot 0
        drive(1'b0, 3'd2, 4'd12, 1'b1, 3'd1, 4'd0, 50);
        e0 = rec(in1_cls, in1_cond, in1_src_a, in1_src_b, in1_target);
        @(negedge clk);
        chk("R7 lone slot1 count", 128'(out_count), 128'(1));
        chk("R7 lone slot1 data", 128'(o0v()), 128'(e0));
        chk("R7 lone slot1 upper zero", 128'(o1v()), 128'(0));
        // R7 jump next cycle in slot 0: no cross-cycle fusion
        drive(1'b1, 3'd2, 4'd12, 1'b0, 3'd0, 4'd0, 51);
        e0 = rec(in0_cls, in0_cond, in0_src_a, in0_src_b, in0_target);
        @(negedge clk);
        chk("R7 cross-cycle count", 128'(out_count), 128'(1));
        chk("R7 cross-cycle cls", 128'(out0_cls), 128'(2));
        chk("R7 cross-cycle data", 128'(o0v()), 128'(e0));
        idle();
        @(negedge clk);

        // R8 backpressure: fused result held while new pair waits
        drive(1'b1, 3'd1, 4'd0, 1'b1, 3'd2, 4'd13, 60);
        e0 = rec(3'd5, in1_cond, in0_src_a, in0_src_b, in1_target);
        out_ready = 1'b0;
        @(negedge clk);
        chk("R8 accepted fused", 128'(o0v()), 128'(e0));
        held0 = e0;
        drive(1'b1, 3'd0, 4'd3, 1'b1, 3'd3, 4'd5, 61);
        e0 = rec(in0_cls, in0_cond, in0_src_a, in0_src_b, in0_target);
        e1 = rec(in1_cls, in1_cond, in1_src_a, in1_src_b, in1_target);
        @(negedge clk);
        chk("R8 stalled ready low", 128'(in_ready), 128'(0));
        chk("R8 stalled hold data", 128'(o0v()), 128'(held0));
        chk("R8 stalled hold count", 128'(out_count), 128'(1));
        @(negedge clk);
        chk("R8 still held", 128'(o0v()), 128'(held0));
        out_ready = 1'b1;
        #1;
        chk("R8 ready follows out_ready", 128'(in_ready), 128'(1));
        @(negedge clk);
        chk("R8 next pair count", 128'(out_count), 128'(2));
        chk("R8 next pair slot0", 128'(o0v()), 128'(e0));
        chk("R8 next pair slot1", 128'(o1v()), 128'(e1));
        idle();

        // R1 fused class and R5 same outcome in both modes
        for (int m = 0; m < 2; m++) begin
            @(negedge clk);
            mode_64 = m[0];
            drive(1'b1, 3'd1, 4'd0, 1'b1, 3'd2, 4'd14, 70 + m);
            @(negedge clk);
            chk($sformatf("R1 fused class mode %0d", m), 128'(out0_cls), 128'(5));
            chk($sformatf("R5 fused count mode %0d", m), 128'(out_count), 128'(1));
            idle();
        end

        // R9 reset mid-stream clears output
        drive(1'b1, 3'd0, 4'd0, 1'b1, 3'd0, 4'd0, 80);
        @(negedge clk);
        idle();
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 reset clears valid", 128'(out_valid), 128'(0));
        chk("R9 reset clears count", 128'(out_count), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule